// File: doc/BRIEF.md
# Q7 Hyperbolic-Tangent and Logistic Activation Unit

This block evaluates either a hyperbolic tangent or a logistic sigmoid on one signed 8-bit fixed-point operand per cycle, for use between the layers of a small quantised neural network. Operands and results share one format. Bit 7 is the sign and bits 6 and 5 carry the integer weights 2 and 1. Bits 4 to 0 are the fraction, so one LSB is 1/32 and an 8-bit code read as a two's-complement integer `q` stands for `q/32`.

The tanh core sees only the operand magnitude and sorts it into one of three regions:
- `RG_LINEAR`: the magnitude passes straight through.
- `RG_TABLE`: seventeen stored breakpoints pick one of the equally spaced levels 15/32 to 31/32.
- `RG_SATURATE`: the result is clamped to 1.0.

The sign is then put back. A sigmoid request halves the operand with an arithmetic shift and runs it through the same core. The block then applies `(t + 1) / 2` to the signed core result. One request enters per cycle, and its result appears one cycle later with a valid flag.

Top module: `act_q7_unit`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `out_valid` is 0 and `y_out` is 0.
- R2: `out_valid` equals `in_valid` of the previous clock edge. A request accepted at edge N has its result on `y_out` after edge N+1.
- R3: With `func_sel`=0 (tanh), an input `q` with |q| <= 14 gives `y_out` = `q` exactly.
- R4: With tanh, an input with 15 <= |q| <= 77 gives a magnitude between 15 and 31. For positive inputs the magnitude never decreases as `q` grows.
- R5: With tanh, an input with 78 <= |q| <= 127 gives +32 or -32, matching the input sign.
- R6: The tanh result is odd: the result for -q is the negation of the result for q, for every q in -127..127.
- R7: The input code 0x80 (-4.0) gives a tanh result of -32 with no wrap-around.
- R8: With `func_sel`=1 (sigmoid), the result equals `floor((T + 32) / 2)`, where T is the tanh result for `floor(q / 2)`. It always lies in 0..32.
- R9: `func_sel` is taken afresh with every request. Requests that alternate between the two functions on consecutive cycles each give their own function's result.
- R10: For all 256 input codes, both functions stay within 2 LSB (2/32) of the exact real-valued function.
- R11: While `in_valid` is 0, `y_out` holds its last value whatever `x_in` and `func_sel` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request is presented this cycle |
| func_sel | input | 1 | 0 selects tanh, 1 selects sigmoid |
| x_in | input | 8 | Operand, signed, 5 fraction bits |
| out_valid | output | 1 | `y_out` carries a fresh result |
| y_out | output | 8 | Result, signed, 5 fraction bits |

## Verification
Two things can fall in the same cycle. A tanh result can leave the register while a sigmoid request enters, and the reverse, so the operand halving and the `(t+1)/2` offset must switch on the incoming select while the registered result still belongs to the previous one. The bench provokes this by toggling `func_sel` on every cycle of a streamed run over a spread of operands. It judges each result against the value that the same operand gave under that function in a separate single-function sweep. The second overlap is a request boundary followed by idle cycles in which `x_in` and `func_sel` keep changing. There the bench requires the last result to stay put.

// File: rtl/act_q7_pkg.sv
`timescale 1ns/1ps
package act_q7_pkg;

    localparam int unsigned Q_W      = 8;
    localparam int unsigned FRAC_W   = 5;
    localparam int unsigned MAG_W    = Q_W - 1;
    localparam int unsigned LVL_W    = FRAC_W + 1;
    localparam int unsigned ONE_Q    = 1 << FRAC_W;
    localparam int unsigned LIN_MAX  = 14;
    localparam int unsigned LVL_BASE = 15;
    localparam int unsigned N_BP     = 17;
    localparam int unsigned CNT_W    = $clog2(N_BP + 1);

    typedef enum logic [1:0] {
        RG_LINEAR,
        RG_TABLE,
        RG_SATURATE
    } region_e;

    // Largest magnitude that still maps to level LVL_BASE+k: the Q-code just
    // below where the inverse tanh passes the midpoint to the next level.
    function automatic logic [MAG_W-1:0] bp_of(input int k);
        logic [MAG_W-1:0] r;
        case (k)
            0:  r = 7'd16;
            1:  r = 7'd18;
            2:  r = 7'd19;
            3:  r = 7'd21;
            4:  r = 7'd22;
            5:  r = 7'd24;
            6:  r = 7'd26;
            7:  r = 7'd27;
            8:  r = 7'd30;
            9:  r = 7'd32;
            10: r = 7'd34;
            11: r = 7'd37;
            12: r = 7'd41;
            13: r = 7'd45;
            14: r = 7'd51;
            15: r = 7'd59;
            16: r = 7'd77;
            default: r = '1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/act_q7_mag.sv
`timescale 1ns/1ps
module act_q7_mag #(
    parameter int unsigned W = 8
) (
    input  logic signed [W-1:0] v,
    output logic [W-2:0]        mag,
    output logic                neg
);
    localparam logic [W-2:0] MAG_MAX = '1;

    logic is_min;

    always_comb begin
        neg    = v[W-1];
        is_min = v[W-1] && (v[W-2:0] == '0);
        if (is_min) begin
            mag = MAG_MAX;
        end else if (neg) begin
            mag = ~v[W-2:0] + 1'b1;
        end else begin
            mag = v[W-2:0];
        end
    end
endmodule

// File: rtl/act_q7_tanh_core.sv
`timescale 1ns/1ps
module act_q7_tanh_core
    import act_q7_pkg::*;
(
    input  logic [MAG_W-1:0] mag,
    output logic [LVL_W-1:0] res
);
    logic [N_BP-1:0]  over;
    logic [CNT_W-1:0] n_over;
    region_e          region;

    for (genvar k = 0; k < N_BP; k++) begin : g_bp
        localparam logic [MAG_W-1:0] BP_K = bp_of(k);
        assign over[k] = (mag > BP_K);
    end

    // Breakpoints ascend, so the count of exceeded ones is the level index.
    always_comb begin
        n_over = '0;
        for (int k = 0; k < N_BP; k++) begin
            n_over = n_over + CNT_W'(over[k]);
        end
    end

    always_comb begin
        if (mag <= MAG_W'(LIN_MAX)) begin
            region = RG_LINEAR;
        end else if (over[N_BP-1]) begin
            region = RG_SATURATE;
        end else begin
            region = RG_TABLE;
        end
    end

    always_comb begin
        unique case (region)
            RG_LINEAR:   res = mag[LVL_W-1:0];
            RG_TABLE:    res = LVL_W'(LVL_BASE) + LVL_W'(n_over);
            RG_SATURATE: res = LVL_W'(ONE_Q);
            default:     res = '0;
        endcase
    end
endmodule

// File: rtl/act_q7_unit.sv
`timescale 1ns/1ps
module act_q7_unit
    import act_q7_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             func_sel,
    input  logic [Q_W-1:0]   x_in,
    output logic             out_valid,
    output logic [Q_W-1:0]   y_out
);
    localparam logic signed [Q_W-1:0] HALF_ONE = Q_W'(ONE_Q / 2);

    logic signed [Q_W-1:0] xs;
    logic signed [Q_W-1:0] core_arg;
    logic [MAG_W-1:0]      mag;
    logic                  neg;
    logic [LVL_W-1:0]      core_mag;
    logic signed [Q_W-1:0] t_pos;
    logic signed [Q_W-1:0] t_val;
    logic signed [Q_W-1:0] s_val;
    logic [Q_W-1:0]        y_next;

    assign xs       = signed'(x_in);
    assign core_arg = func_sel ? (xs >>> 1) : xs;

    act_q7_mag #(.W(Q_W)) u_mag (
        .v   (core_arg),
        .mag (mag),
        .neg (neg)
    );

    act_q7_tanh_core u_core (
        .mag (mag),
        .res (core_mag)
    );

    always_comb begin
        t_pos  = signed'({{(Q_W-LVL_W){1'b0}}, core_mag});
        t_val  = neg ? -t_pos : t_pos;
        // floor((t + 1.0) / 2) == floor(t / 2) + 0.5 for integer Q codes
        s_val  = (t_val >>> 1) + HALF_ONE;
        y_next = func_sel ? s_val : t_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            y_out     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                y_out <= y_next;
            end
        end
    end
endmodule

// File: rtl/act_q7_unit_chk.sv
`timescale 1ns/1ps
module act_q7_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       func_sel,
    input logic [7:0] x_in,
    input logic       out_valid,
    input logic [7:0] y_out
);
    logic signed [7:0] xs;
    logic signed [7:0] ys;
    assign xs = signed'(x_in);
    assign ys = signed'(y_out);

    a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(y_out));

    a_r3_linear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !func_sel && xs >= -8'sd14 && xs <= 8'sd14)
        |=> (y_out == $past(x_in)));

    a_r5_saturate_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !func_sel && xs >= 8'sd78) |=> (ys == 8'sd32));

    a_r5_saturate_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !func_sel && xs <= -8'sd78) |=> (ys == -8'sd32));

    a_r8_sig_range: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && func_sel) |=> (ys >= 8'sd0 && ys <= 8'sd32));

    a_r4_tanh_range: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !func_sel) |=> (ys >= -8'sd32 && ys <= 8'sd32));
endmodule

bind act_q7_unit act_q7_unit_chk u_chk (.*);

// File: tb/act_q7_unit_bench.sv
`timescale 1ns/1ps
module act_q7_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic       func_sel;
    logic [7:0] x_in;
    logic       out_valid;
    logic [7:0] y_out;

    int n_cmp = 0;
    int n_bad = 0;
    int tanh_res [256];
    int sig_res  [256];
    bit done = 1'b0;

    always #10 clk = ~clk;

    act_q7_unit u_act_q7_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .func_sel(func_sel),
        .x_in(x_in), .out_valid(out_valid), .y_out(y_out)
    );

    function automatic int sval(input int code);
        return (code >= 128) ? code - 256 : code;
    endfunction

    function automatic int yval();
        return sval(int'(y_out));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_tol(input string req, input int act, input real refq);
        real d;
        n_cmp++;
        d = $itor(act) - refq;
        if (d < 0.0) d = -d;
        if (d > 2.0) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0f (+-2)", req, act, refq);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Sweep every code for one function, one request per cycle.
    task automatic sweep(input bit fs);
        for (int i = 0; i <= 256; i++) begin
            @(negedge clk);
            if (i > 0) begin
                int c, q, m, y;
                real xr;
                c  = i - 1;
                q  = sval(c);
                y  = yval();
                xr = $itor(q) / 32.0;
                check("R2 out_valid during stream", int'(out_valid), 1);
                if (!fs) begin
                    tanh_res[c] = y;
                    m = (q < 0) ? -q : q;
                    if (m > 127) m = 127;
                    check_tol("R10 tanh accuracy", y, 32.0 * $tanh(xr));
                    if (m <= 14) check("R3 linear pass", y, q);
                    else if (m >= 78) check("R5 saturation", y, (q < 0) ? -32 : 32);
                    else check("R4 table magnitude in 15..31",
                               int'(((y < 0) ? -y : y) >= 15 && ((y < 0) ? -y : y) <= 31), 1);
                    if (c == 128) check("R7 most negative code", y, -32);
                end else begin
                    sig_res[c] = y;
                    check_tol("R10 sigmoid accuracy", y, 32.0 / (1.0 + $exp(-xr)));
                    check("R8 sigmoid range", int'(y >= 0 && y <= 32), 1);
                end
            end
            if (i < 256) begin
                in_valid = 1'b1;
                func_sel = fs;
                x_in     = 8'(i);
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            summary();
        end
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        func_sel = 1'b0;
        x_in     = 8'h00;
        repeat (3) @(negedge clk);
        check("R1 reset out_valid", int'(out_valid), 0);
        check("R1 reset y_out", int'(y_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release out_valid", int'(out_valid), 0);
        check("R1 after release y_out", int'(y_out), 0);

        sweep(1'b0);
        sweep(1'b1);

        // R4: monotone over the table region for positive inputs
        for (int q = 15; q <= 77; q++)
            check("R4 monotone", int'(tanh_res[q] >= tanh_res[q-1]), 1);

        // R6: odd symmetry
        for (int q = 1; q <= 127; q++)
            check("R6 odd symmetry", tanh_res[256 - q], -tanh_res[q]);

        // R8: composition through the tanh core
        for (int c = 0; c < 256; c++) begin
            int h;
            h = sval(c) >>> 1;
            check("R8 sigmoid via tanh", sig_res[c], (tanh_res[h & 255] + 32) >>> 1);
        end

        // R9: alternating selects, back to back
        begin
            int  pc;
            bit  pf;
            bit  have;
            have = 1'b0;
            pc   = 0;
            pf   = 1'b0;
            for (int k = 0; k <= 64; k++) begin
                @(negedge clk);
                if (have)
                    check("R9 alternating select", yval(),
                          pf ? sig_res[pc] : tanh_res[pc]);
                if (k < 64) begin
                    pc       = (k * 37 + 5) & 255;
                    pf       = k[0];
                    in_valid = 1'b1;
                    func_sel = pf;
                    x_in     = 8'(pc);
                    have     = 1'b1;
                end else begin
                    in_valid = 1'b0;
                end
            end
        end

        // R11: idle cycles keep the last result
        @(negedge clk);
        in_valid = 1'b1; func_sel = 1'b0; x_in = 8'd20;
        @(negedge clk);
        in_valid = 1'b0; func_sel = 1'b1; x_in = 8'h9C;
        check("R2 result valid", int'(out_valid), 1);
        check("R11 held value loaded", yval(), tanh_res[20]);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            x_in = 8'(k * 70 + 3); func_sel = ~func_sel;
            check("R2 idle out_valid", int'(out_valid), 0);
            check("R11 hold while idle", yval(), tanh_res[20]);
        end

        done = 1'b1;
        summary();
    end
endmodule